// File: doc/BRIEF.md
# Software-Driven Parallel Port Decoder

This block sits in an FPGA and listens to a 32-bit general-purpose port that a microcontroller toggles from software. The port has no clock of its own. The host uses one shared word-wide bus. It first places an address on that bus and later places data on it. A START strobe frames each phase. Two qualifier lines, WR and RD, mark whether the phase that begins a transfer is a write or a read.

The decoder passes START, WR and RD through two-flop synchronizers and finds the edges of START. On the synchronized rising edge of START it latches the bus word and the qualifier levels. On the synchronized falling edge, when the host clears its control lines, it acts on the phase.

A write is made of two phases. The first is an address phase marked WR. The second is a data phase with START alone. When the data phase completes, the data lands in one of sixteen 32-bit registers, and the block emits a one-clock write pulse with the register index and the data.

A read needs only one phase, an address phase marked RD. The decoder then drives the addressed register back toward the host through split pad signals (data out plus output enable). It keeps driving until START rises again.

Top module: `gpio_bus_decoder`

## Requirements
- R1: After reset, `busOe` and `regWe` are low and every register reads back as zero.
- R2: If the falling edge of `startIn` is first sampled low at clock edge k, the write pulse `regWe` is high after edge k+2 and at no other cycle of that phase.
- R3: A transfer is a write when its address phase is START with WR high and RD low, and a data phase with START alone follows. The data phase stores its bus word in the register selected by address bits [5:2]. `regWe` is high for exactly one clock, with `regIdx` equal to those bits and `regWdata` equal to the word.
- R4: A transfer is a read when its address phase is START with RD high and WR low. Once that phase ends, `busOe` is high from edge k+2 and `busOut` carries the selected register. Both hold until a later rising edge of `startIn`, first sampled high at edge j. After edge j+2, `busOe` is low.
- R5: An address whose bits [31:6] are not all zero is unmapped. A write to it changes no register and raises no `regWe`. A read of it drives zero with `busOe` high.
- R6: While idle, a START whose captured qualifiers are both low or both high is ignored. It does not drive the bus, does not pulse `regWe`, and does not disturb the next transfer.
- R7: Address bits [1:0] do not affect which register is selected.
- R8: The bus word is taken at the synchronized rising edge of START. Later changes on `busIn` while START stays high do not alter the stored value.
- R9: The rising START that ends a read drive also begins the next phase, so transfers may follow each other with no idle phase between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Host phase strobe, asynchronous |
| wrIn | input | 1 | Host write qualifier, asynchronous |
| rdIn | input | 1 | Host read qualifier, asynchronous |
| busIn | input | 32 | Pad input side of the shared address/data bus |
| busOut | output | 32 | Pad output side of the bus (read data) |
| busOe | output | 1 | Pad output enable; low means high impedance |
| regWe | output | 1 | One-clock write pulse toward the register interface |
| regIdx | output | 4 | Register index of the write pulse |
| regWdata | output | 32 | Data of the write pulse |

## Verification
The assertions rely on certain host behaviour.
- The host holds every START level for at least three clocks.
- WR and RD change together with START.
- `busIn` is steady from before START rises until the synchronized rise has latched it.

Under these conditions, write pulses are isolated and a read drive ends only after a rising START. The stimulus changes every host line on the falling clock edge and holds each level for four clocks. It alters the bus during a START only after the latch point, which is the case the R8 test exercises.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR_WR = 2'd1,
    ST_ADDR_RD = 2'd2
  } phase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // synchronized START rise: latch bus word
    logic takeAddr;  // address phase complete
    logic writeReg;  // write data phase complete
    logic drive;     // read data on the pads
  } strobe_t;
endpackage

// File: rtl/gpd_sync.sv
module gpd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startS,
  input  logic    wrS,
  input  logic    rdS,
  output strobe_t strb
);
  logic   startD, capWr, capRd, rise, fall, validMode;
  phase_t state;

  assign rise      = startS & ~startD;
  assign fall      = ~startS & startD;
  assign validMode = capWr ^ capRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startD <= 1'b0;
      capWr  <= 1'b0;
      capRd  <= 1'b0;
      state  <= ST_IDLE;
    end else begin
      startD <= startS;
      if (rise) begin
        capWr <= wrS;
        capRd <= rdS;
      end
      unique case (state)
        ST_IDLE:
          if (fall && validMode) state <= capWr ? ST_ADDR_WR : ST_ADDR_RD;
        ST_ADDR_WR:
          if (fall) state <= ST_IDLE;
        ST_ADDR_RD:
          if (rise) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture  = rise;
    strb.takeAddr = fall && (state == ST_IDLE) && validMode;
    strb.writeReg = fall && (state == ST_ADDR_WR);
    strb.drive    = (state == ST_ADDR_RD);
  end

  // R4: the read drive only ends after a START rise.
  assert_drive_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.drive) |-> $past(rise));

  // R6: an unqualified phase leaves the decoder idle.
  assert_ignored_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fall && state == ST_IDLE && capWr == capRd) |=> (state == ST_IDLE));
endmodule

// File: rtl/gpd_datapath.sv
module gpd_datapath
  import gpd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16,
  parameter int IDX_LO    = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [DATA_W-1:0]            busIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  output logic                         regWe,
  output logic [$clog2(REG_COUNT)-1:0] regIdx,
  output logic [DATA_W-1:0]            regWdata
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam int TOP_LO = IDX_LO + IDX_W;

  logic [DATA_W-1:0] busLatch, addrReg;
  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [IDX_W-1:0]  idx;
  logic              mapped;

  assign idx    = addrReg[IDX_LO +: IDX_W];
  assign mapped = (addrReg[DATA_W-1:TOP_LO] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busLatch <= '0;
      addrReg  <= '0;
      regWe    <= 1'b0;
      regIdx   <= '0;
      regWdata <= '0;
    end else begin
      if (strb.capture)  busLatch <= busIn;
      if (strb.takeAddr) addrReg  <= busLatch;
      regWe <= strb.writeReg && mapped;
      if (strb.writeReg) begin
        regIdx   <= idx;
        regWdata <= busLatch;
      end
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[g] <= '0;
      else if (strb.writeReg && mapped && idx == IDX_W'(g)) regs[g] <= busLatch;
    end
  end

  assign busOe  = strb.drive;
  assign busOut = (strb.drive && mapped) ? regs[idx] : '0;

  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(busOe && regWe));

  assert_read_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $past(busOe)) |-> $stable(busOut));

  assert_unmapped_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeReg && !mapped) |=> !regWe);
endmodule

// File: rtl/gpio_bus_decoder.sv
module gpio_bus_decoder
  import gpd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startIn,
  input  logic                         wrIn,
  input  logic                         rdIn,
  input  logic [DATA_W-1:0]            busIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  output logic                         regWe,
  output logic [$clog2(REG_COUNT)-1:0] regIdx,
  output logic [DATA_W-1:0]            regWdata
);
  localparam int IDX_LO = $clog2(DATA_W / 8);

  logic [2:0] ctlSync;
  strobe_t    strb;

  gpd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .din({startIn, wrIn, rdIn}), .dout(ctlSync)
  );

  gpd_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .startS(ctlSync[2]), .wrS(ctlSync[1]), .rdS(ctlSync[0]),
    .strb(strb)
  );

  gpd_datapath #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .IDX_LO(IDX_LO)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn),
    .busOut(busOut), .busOe(busOe),
    .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata)
  );
endmodule

// File: tb/gpio_bus_decoder_test.sv
module gpio_bus_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0, wrIn = 1'b0, rdIn = 1'b0;
  logic [31:0] busIn = '0;
  logic [31:0] busOut, regWdata;
  logic        busOe, regWe;
  logic [3:0]  regIdx;

  int total = 0, failed = 0, cycles = 0;
  bit finished = 0;
  logic [31:0] shadow [16];

  gpio_bus_decoder uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .wrIn(wrIn), .rdIn(rdIn),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural cycle model: queues of sampled host lines.
  bit          hS[$], hW[$], hR[$];
  int          mSt;
  bit          mCw, mCr, mWe;
  logic [31:0] mLatch, mAddr, mRegs [16], mWd;
  logic [3:0]  mIdx;

  function automatic bit isMapped(logic [31:0] a);
    return a[31:6] == 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hS = {0, 0, 0}; hW = {0, 0, 0}; hR = {0, 0, 0};
      mSt = 0; mCw = 0; mCr = 0; mWe = 0; mLatch = 0; mAddr = 0; mWd = 0; mIdx = 0;
      foreach (mRegs[i]) mRegs[i] = 0;
    end else begin
      mWe = 0;
      if (hS[1] && !hS[2]) begin
        mLatch = busIn; mCw = hW[1]; mCr = hR[1];
        if (mSt == 2) mSt = 0;
      end else if (!hS[1] && hS[2]) begin
        if (mSt == 0 && (mCw != mCr)) begin
          mAddr = mLatch; mSt = mCw ? 1 : 2;
        end else if (mSt == 1) begin
          if (isMapped(mAddr)) begin
            mRegs[mAddr[5:2]] = mLatch; mWe = 1; mIdx = mAddr[5:2]; mWd = mLatch;
          end
          mSt = 0;
        end
      end
      hS.push_front(startIn); hW.push_front(wrIn); hR.push_front(rdIn);
      void'(hS.pop_back()); void'(hW.pop_back()); void'(hR.pop_back());
    end
  end

  // Per-cycle comparison against the model (R2 R3 R4 R5 R6).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [31:0] expOut;
      expOut = (mSt == 2 && isMapped(mAddr)) ? mRegs[mAddr[5:2]] : 32'h0;
      check("R4 cycle busOe", {31'b0, busOe}, {31'b0, mSt == 2});
      if (mSt == 2) check("R4 cycle busOut", busOut, expOut);
      check("R2 cycle regWe", {31'b0, regWe}, {31'b0, mWe});
      if (mWe) begin
        check("R3 cycle regIdx", {28'b0, regIdx}, {28'b0, mIdx});
        check("R3 cycle regWdata", regWdata, mWd);
      end
    end
  end

  // One host phase: level high for 4 clocks, then clear for 4 clocks.
  task automatic phase(logic [31:0] word, bit wr, bit rd, bit weExp, bit morph, string tag);
    busIn = word; startIn = 1; wrIn = wr; rdIn = rd;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (morph && i == 3) busIn = ~word;
    end
    startIn = 0; wrIn = 0; rdIn = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check({tag, " regWe timing"}, {31'b0, regWe}, {31'b0, weExp && i == 3});
    end
  endtask

  task automatic hostWrite(logic [31:0] addr, logic [31:0] data, bit morph, string tag);
    bit ok;
    ok = (addr[31:6] == 0);
    phase(addr, 1, 0, 0, 0, tag);
    phase(data, 0, 0, ok, morph, tag);
    if (ok) shadow[addr[5:2]] = data;
  endtask

  task automatic hostRead(logic [31:0] addr, string tag);
    logic [31:0] exp;
    exp = (addr[31:6] == 0) ? shadow[addr[5:2]] : 32'h0;
    phase(addr, 0, 1, 0, 0, tag);
    busIn = 32'hDEAD_BEEF;
    check({tag, " read oe"}, {31'b0, busOe}, 32'h1);
    check({tag, " read data"}, busOut, exp);
    repeat (3) @(negedge clk);
    check("R4 drive held", {31'b0, busOe}, 32'h1);
    check("R4 data held", busOut, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failed++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    foreach (shadow[i]) shadow[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset busOe", {31'b0, busOe}, 32'h0);
    check("R1 reset regWe", {31'b0, regWe}, 32'h0);
    rstN = 1;
    @(negedge clk);
    hostRead(32'h0000_000C, "R1");
    hostWrite(32'h0000_000C, 32'hA5A5_5A5A, 0, "R3");
    hostRead(32'h0000_000C, "R3");
    hostWrite(32'h0000_0000, 32'h1234_5678, 0, "R3");
    hostWrite(32'h0000_003C, 32'hFFFF_0001, 0, "R3");
    hostWrite(32'h0000_001C, 32'h0F0F_F0F0, 0, "R2");
    hostRead(32'h0000_0000, "R3");
    // Unmapped traffic.
    hostWrite(32'h0000_0040, 32'hBAD0_BAD0, 0, "R5");
    hostRead(32'h0000_0040, "R5");
    hostRead(32'h0000_0000, "R5");
    // Low address bits.
    hostWrite(32'h0000_0017, 32'h7777_0000, 0, "R7");
    hostRead(32'h0000_0014, "R7");
    hostRead(32'h0000_003D, "R7");
    // Ignored phases, then a normal transfer.
    phase(32'h0000_0008, 0, 0, 0, 0, "R6");
    check("R6 no drive", {31'b0, busOe}, 32'h0);
    phase(32'h0000_0008, 1, 1, 0, 0, "R6");
    check("R6 no drive both", {31'b0, busOe}, 32'h0);
    hostWrite(32'h0000_0008, 32'hC0DE_0008, 0, "R6");
    hostRead(32'h0000_0008, "R6");
    // Bus changing after the latch point.
    hostWrite(32'h0000_0020, 32'h1357_9BDF, 1, "R8");
    hostRead(32'h0000_0020, "R8");
    // Release on next START, back-to-back reads.
    busIn = 32'h0000_001C; startIn = 1; rdIn = 1;
    @(negedge clk); check("R4 still driving", {31'b0, busOe}, 32'h1);
    @(negedge clk); check("R4 still driving", {31'b0, busOe}, 32'h1);
    @(negedge clk); check("R4 released", {31'b0, busOe}, 32'h0);
    @(negedge clk);
    startIn = 0; rdIn = 0;
    repeat (4) @(negedge clk);
    check("R9 chained read oe", {31'b0, busOe}, 32'h1);
    check("R9 chained read data", busOut, shadow[7]);
    hostWrite(32'h0000_0004, 32'h0000_00FF, 0, "R9");
    hostRead(32'h0000_0004, "R9");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule